// File: doc/BRIEF.md
# Deferred Load Write-Back Buffer

This block controls the single write port of an integer register file in an in-order pipeline. An integer instruction in execute always gets that port in the cycle that follows. Data that a load brings back from memory has no claim on the port. Instead it is parked in a one-entry pending buffer together with the register index it targets. The buffer empties into the register file in the first cycle where no integer result is being written. A load or store instruction always leaves such a cycle behind it, because it produces no result of its own. Until the parked value lands, each operand read port sees it through a forwarding mux.

The pending entry is controlled by a two-state machine, EMPTY and HELD. Its transitions are named:
- CAPTURE (EMPTY to HELD): a load return is accepted.
- WAIT (HELD stays HELD): the port is taken by an integer result.
- SWAP (HELD stays HELD): the held entry drains and a new return takes its place in the same cycle.
- DRAIN (HELD to EMPTY): the held entry is written and nothing replaces it.
- KILL (HELD to EMPTY): a younger integer result targets the same register.
- IDLE (EMPTY stays EMPTY): nothing happens.

The surrounding logic must follow two rules. First, no load may return in a cycle where an entry is held and an integer result owns the port. Second, an integer issue and a load/store issue never occur in the same cycle.

Top module: `dlwb_buffer`

## Requirements
- R1: While reset is asserted and directly after it, the write enable is low, no entry is pending, and every read port returns the register-file data it is given.
- R2: An integer result issued in cycle t appears on the write port in cycle t+1 with its register index and value, whatever the pending buffer holds.
- R3: Load data returned in cycle t is written on the port in the first cycle after t in which no integer result is being written, and never in cycle t itself.
- R4: While an integer result owns the port, a held entry for a different register stays held, with its index and data unchanged.
- R5: In the cycle after a load/store issue, the write port carries the held entry if one exists, and is idle otherwise.
- R6: When a load returns while an entry is held and the port is free, the held entry is written in that cycle and the new data becomes the held entry.
- R7: When an integer result is written to the register that the held entry targets, the held entry is discarded and never written.
- R8: A load return whose register equals that of the integer result being written in the same cycle is discarded.
- R9: A read port returns the integer result being written in this cycle if the register matches. Failing that, it returns the held load data if the register matches. Otherwise it returns the register-file data.
- R10: Each read port applies R9 independently, using its own address and its own register-file data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_int_vld | input | 1 | Integer instruction in execute this cycle |
| iss_int_rd | input | AW | Destination register of that instruction |
| iss_int_data | input | DW | Its result |
| iss_ldst_vld | input | 1 | Load or store instruction in execute this cycle |
| ldr_vld | input | 1 | Load data returns from memory this cycle |
| ldr_rd | input | AW | Destination register of the returning load |
| ldr_data | input | DW | Returned load data |
| rd_addr | input | NRD x AW | Operand read addresses, one per read port |
| rf_rdata | input | NRD x DW | Register-file contents at those addresses |
| rd_fwd | output | NRD x DW | Operand values after forwarding |
| wp_en | output | 1 | Register-file write enable |
| wp_addr | output | AW | Register-file write index |
| wp_data | output | DW | Register-file write value |

## Verification
Two events can meet in one cycle: the held entry draining and a new load return being captured (SWAP). They collide when a load returns into the free slot that a load/store leaves behind. The bench provokes this with a directed sequence and with a random phase that freely mixes returns with load/store issues. A reference model keeps a queue of pending loads and a behavioural register file. On every cycle it checks that the older value reaches the write port while the newer one is forwarded on the next cycle, and that neither is lost or written twice. The kill and drop cases are judged the same way: the model predicts the final contents of the target register, and the bench reads them back through the forwarding ports.

// File: rtl/dlwb_pkg.sv
package dlwb_pkg;

    // what occupies the write-back stage this cycle
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'b00,
        SLOT_INT  = 2'b01,
        SLOT_LDST = 2'b10
    } slot_kind_e;

    // occupancy of the single pending entry
    typedef enum logic [0:0] {
        PEND_EMPTY = 1'b0,
        PEND_HELD  = 1'b1
    } pend_state_e;

    // named transitions of the pending-entry machine
    typedef enum logic [2:0] {
        TR_IDLE,
        TR_CAPTURE,
        TR_WAIT,
        TR_SWAP,
        TR_DRAIN,
        TR_KILL
    } pend_trans_e;

endpackage

// File: rtl/dlwb_wb_stage.sv
module dlwb_wb_stage
    import dlwb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_int_vld,
    input  logic [AW-1:0] iss_int_rd,
    input  logic [DW-1:0] iss_int_data,
    input  logic          iss_ldst_vld,
    output slot_kind_e    wb_kind,
    output logic [AW-1:0] wb_rd,
    output logic [DW-1:0] wb_data
);

    slot_kind_e kind_nxt;

    always_comb begin
        if (iss_int_vld)
            kind_nxt = SLOT_INT;
        else if (iss_ldst_vld)
            kind_nxt = SLOT_LDST;
        else
            kind_nxt = SLOT_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_kind <= SLOT_IDLE;
            wb_rd   <= '0;
            wb_data <= '0;
        end else begin
            wb_kind <= kind_nxt;
            if (iss_int_vld) begin
                wb_rd   <= iss_int_rd;
                wb_data <= iss_int_data;
            end
        end
    end

endmodule

// File: rtl/dlwb_pend_fsm.sv
module dlwb_pend_fsm
    import dlwb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_kind_e    wb_kind,
    input  logic [AW-1:0] wb_rd,
    input  logic          ldr_vld,
    input  logic [AW-1:0] ldr_rd,
    input  logic [DW-1:0] ldr_data,
    output logic          pend_vld,
    output logic [AW-1:0] pend_rd,
    output logic [DW-1:0] pend_data,
    output logic          drain_go
);

    pend_state_e state_q, state_d;
    pend_trans_e trans;

    logic port_free;
    logic accept;
    logic overwrite;

    // an integer result owns the port only in an integer write-back slot
    assign port_free = (wb_kind != SLOT_INT);
    // a return aimed at the register being written by a younger integer op is stale
    assign accept    = ldr_vld && !(!port_free && (wb_rd == ldr_rd));
    assign overwrite = !port_free && (wb_rd == pend_rd);

    // transition selection
    always_comb begin
        trans = TR_IDLE;
        unique case (state_q)
            PEND_EMPTY: begin
                if (accept)
                    trans = TR_CAPTURE;
                else
                    trans = TR_IDLE;
            end
            PEND_HELD: begin
                if (accept)
                    trans = TR_SWAP;
                else if (overwrite)
                    trans = TR_KILL;
                else if (port_free)
                    trans = TR_DRAIN;
                else
                    trans = TR_WAIT;
            end
            default: trans = TR_IDLE;
        endcase
    end

    always_comb begin
        unique case (trans)
            TR_CAPTURE, TR_SWAP, TR_WAIT: state_d = PEND_HELD;
            TR_IDLE, TR_DRAIN, TR_KILL:   state_d = PEND_EMPTY;
            default:                      state_d = PEND_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PEND_EMPTY;
        else
            state_q <= state_d;
    end

    // entry payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_rd   <= '0;
            pend_data <= '0;
        end else if (trans == TR_CAPTURE || trans == TR_SWAP) begin
            pend_rd   <= ldr_rd;
            pend_data <= ldr_data;
        end
    end

    // outputs
    always_comb begin
        pend_vld = 1'b0;
        drain_go = 1'b0;
        unique case (state_q)
            PEND_EMPTY: begin
                pend_vld = 1'b0;
                drain_go = 1'b0;
            end
            PEND_HELD: begin
                pend_vld = 1'b1;
                drain_go = port_free;
            end
            default: begin
                pend_vld = 1'b0;
                drain_go = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dlwb_fwd.sv
module dlwb_fwd
    import dlwb_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rf_rdata,
    input  slot_kind_e    wb_kind,
    input  logic [AW-1:0] wb_rd,
    input  logic [DW-1:0] wb_data,
    input  logic          pend_vld,
    input  logic [AW-1:0] pend_rd,
    input  logic [DW-1:0] pend_data,
    output logic [DW-1:0] rd_fwd
);

    logic hit_int;
    logic hit_pend;

    assign hit_int  = (wb_kind == SLOT_INT) && (wb_rd == rd_addr);
    assign hit_pend = pend_vld && (pend_rd == rd_addr);

    always_comb begin
        if (hit_int)
            rd_fwd = wb_data;
        else if (hit_pend)
            rd_fwd = pend_data;
        else
            rd_fwd = rf_rdata;
    end

endmodule

// File: rtl/dlwb_buffer.sv
module dlwb_buffer
    import dlwb_pkg::*;
#(
    parameter  int DW   = 32,
    parameter  int NREG = 64,
    parameter  int NRD  = 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_int_vld,
    input  logic [AW-1:0]           iss_int_rd,
    input  logic [DW-1:0]           iss_int_data,
    input  logic                    iss_ldst_vld,
    input  logic                    ldr_vld,
    input  logic [AW-1:0]           ldr_rd,
    input  logic [DW-1:0]           ldr_data,
    input  logic [NRD-1:0][AW-1:0]  rd_addr,
    input  logic [NRD-1:0][DW-1:0]  rf_rdata,
    output logic [NRD-1:0][DW-1:0]  rd_fwd,
    output logic                    wp_en,
    output logic [AW-1:0]           wp_addr,
    output logic [DW-1:0]           wp_data
);

    slot_kind_e    wb_kind;
    logic [AW-1:0] wb_rd;
    logic [DW-1:0] wb_data;
    logic          pend_vld;
    logic [AW-1:0] pend_rd;
    logic [DW-1:0] pend_data;
    logic          drain_go;

    dlwb_wb_stage #(.DW(DW), .AW(AW)) u_wb (
        .clk          (clk),
        .rst_n        (rst_n),
        .iss_int_vld  (iss_int_vld),
        .iss_int_rd   (iss_int_rd),
        .iss_int_data (iss_int_data),
        .iss_ldst_vld (iss_ldst_vld),
        .wb_kind      (wb_kind),
        .wb_rd        (wb_rd),
        .wb_data      (wb_data)
    );

    dlwb_pend_fsm #(.DW(DW), .AW(AW)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_kind   (wb_kind),
        .wb_rd     (wb_rd),
        .ldr_vld   (ldr_vld),
        .ldr_rd    (ldr_rd),
        .ldr_data  (ldr_data),
        .pend_vld  (pend_vld),
        .pend_rd   (pend_rd),
        .pend_data (pend_data),
        .drain_go  (drain_go)
    );

    // write port: the integer result first, otherwise the parked load
    always_comb begin
        wp_en   = 1'b0;
        wp_addr = '0;
        wp_data = '0;
        if (wb_kind == SLOT_INT) begin
            wp_en   = 1'b1;
            wp_addr = wb_rd;
            wp_data = wb_data;
        end else if (drain_go) begin
            wp_en   = 1'b1;
            wp_addr = pend_rd;
            wp_data = pend_data;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        dlwb_fwd #(.DW(DW), .AW(AW)) u_fwd (
            .rd_addr   (rd_addr[g]),
            .rf_rdata  (rf_rdata[g]),
            .wb_kind   (wb_kind),
            .wb_rd     (wb_rd),
            .wb_data   (wb_data),
            .pend_vld  (pend_vld),
            .pend_rd   (pend_rd),
            .pend_data (pend_data),
            .rd_fwd    (rd_fwd[g])
        );
    end

endmodule

// File: rtl/dlwb_buffer_chk.sv
module dlwb_buffer_chk
    import dlwb_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 6,
    parameter int NRD = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   iss_int_vld,
    input logic [AW-1:0]          iss_int_rd,
    input logic [DW-1:0]          iss_int_data,
    input logic                   iss_ldst_vld,
    input logic                   ldr_vld,
    input logic [AW-1:0]          ldr_rd,
    input logic [DW-1:0]          ldr_data,
    input logic [NRD-1:0][AW-1:0] rd_addr,
    input logic [NRD-1:0][DW-1:0] rd_fwd,
    input logic                   wp_en,
    input logic [AW-1:0]          wp_addr,
    input logic [DW-1:0]          wp_data,
    input slot_kind_e             wb_kind,
    input logic [AW-1:0]          wb_rd,
    input logic                   pend_vld,
    input logic [AW-1:0]          pend_rd,
    input logic [DW-1:0]          pend_data
);

    logic int_slot;
    assign int_slot = (wb_kind == SLOT_INT);

    assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !pend_vld || !rst_n);

    assert_int_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_int_vld |=> wp_en && wp_addr == $past(iss_int_rd) && wp_data == $past(iss_int_data));

    assert_drain_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld && !int_slot && !ldr_vld) |=> !pend_vld);

    assert_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld && int_slot && wb_rd != pend_rd && !ldr_vld)
        |=> pend_vld && $stable(pend_rd) && $stable(pend_data));

    assert_ldst_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_ldst_vld && !iss_int_vld) |=> (wp_en == pend_vld));

    assert_issue_mutex_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(iss_int_vld && iss_ldst_vld));

    assert_no_return_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ldr_vld && pend_vld && int_slot));

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ldr_vld && !(int_slot && wb_rd == ldr_rd))
        |=> pend_vld && pend_rd == $past(ldr_rd) && pend_data == $past(ldr_data));

    assert_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld && int_slot && wb_rd == pend_rd && !ldr_vld) |=> !pend_vld);

    assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ldr_vld && int_slot && wb_rd == ldr_rd && !pend_vld) |=> !pend_vld);

    for (genvar g = 0; g < NRD; g++) begin : g_fwd
        // R9 and R10: a reader of the register being written sees the written value
        assert_fwd_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wp_en && wp_addr == rd_addr[g]) |-> rd_fwd[g] == wp_data);
    end

endmodule

bind dlwb_buffer dlwb_buffer_chk #(.DW(DW), .AW(AW), .NRD(NRD)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_int_vld  (iss_int_vld),
    .iss_int_rd   (iss_int_rd),
    .iss_int_data (iss_int_data),
    .iss_ldst_vld (iss_ldst_vld),
    .ldr_vld      (ldr_vld),
    .ldr_rd       (ldr_rd),
    .ldr_data     (ldr_data),
    .rd_addr      (rd_addr),
    .rd_fwd       (rd_fwd),
    .wp_en        (wp_en),
    .wp_addr      (wp_addr),
    .wp_data      (wp_data),
    .wb_kind      (wb_kind),
    .wb_rd        (wb_rd),
    .pend_vld     (pend_vld),
    .pend_rd      (pend_rd),
    .pend_data    (pend_data)
);

// File: tb/dlwb_buffer_bench.sv
`timescale 1ns/1ps
module dlwb_buffer_bench;

    localparam int DW   = 32;
    localparam int NREG = 64;
    localparam int NRD  = 2;
    localparam int AW   = $clog2(NREG);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   iss_int_vld = 1'b0;
    logic [AW-1:0]          iss_int_rd = '0;
    logic [DW-1:0]          iss_int_data = '0;
    logic                   iss_ldst_vld = 1'b0;
    logic                   ldr_vld = 1'b0;
    logic [AW-1:0]          ldr_rd = '0;
    logic [DW-1:0]          ldr_data = '0;
    logic [NRD-1:0][AW-1:0] rd_addr = '0;
    logic [NRD-1:0][DW-1:0] rf_rdata = '0;
    logic [NRD-1:0][DW-1:0] rd_fwd;
    logic                   wp_en;
    logic [AW-1:0]          wp_addr;
    logic [DW-1:0]          wp_data;

    always #2 clk = ~clk;

    dlwb_buffer #(.DW(DW), .NREG(NREG), .NRD(NRD)) u_dlwb_buffer (
        .clk(clk), .rst_n(rst_n),
        .iss_int_vld(iss_int_vld), .iss_int_rd(iss_int_rd), .iss_int_data(iss_int_data),
        .iss_ldst_vld(iss_ldst_vld),
        .ldr_vld(ldr_vld), .ldr_rd(ldr_rd), .ldr_data(ldr_data),
        .rd_addr(rd_addr), .rf_rdata(rf_rdata), .rd_fwd(rd_fwd),
        .wp_en(wp_en), .wp_addr(wp_addr), .wp_data(wp_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    bit          m_wb_v = 1'b0;
    int          m_wb_rd = 0;
    logic [31:0] m_wb_d = '0;
    int          pq_rd[$];
    logic [31:0] pq_d[$];
    logic [31:0] m_rf[NREG];

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(int a);
        if (m_wb_v && m_wb_rd == a) return m_wb_d;
        if (pq_rd.size() > 0 && pq_rd[0] == a) return pq_d[0];
        return m_rf[a];
    endfunction

    task automatic step(string tag, bit av, int ard, logic [31:0] ad, bit mv,
                        bit lv, int lrd, logic [31:0] ld, int ra0, int ra1);
        bit          e_en;
        int          e_addr;
        logic [31:0] e_data;
        @(negedge clk);
        iss_int_vld  = av;
        iss_int_rd   = AW'(ard);
        iss_int_data = ad;
        iss_ldst_vld = mv;
        ldr_vld      = lv;
        ldr_rd       = AW'(lrd);
        ldr_data     = ld;
        rd_addr[0]   = AW'(ra0);
        rd_addr[1]   = AW'(ra1);
        rf_rdata[0]  = m_rf[ra0];
        rf_rdata[1]  = m_rf[ra1];
        #1;
        e_en   = m_wb_v || (pq_rd.size() > 0);
        e_addr = m_wb_v ? m_wb_rd : (pq_rd.size() > 0 ? pq_rd[0] : 0);
        e_data = m_wb_v ? m_wb_d  : (pq_rd.size() > 0 ? pq_d[0]  : '0);
        check(tag, "wp_en", 32'(wp_en), 32'(e_en));
        if (e_en) begin
            check(tag, "wp_addr", 32'(wp_addr), 32'(e_addr));
            check(tag, "wp_data", wp_data, e_data);
        end
        check(tag, "rd_fwd0", rd_fwd[0], model_read(ra0));
        check(tag, "rd_fwd1", rd_fwd[1], model_read(ra1));
        // advance the model by one cycle
        if (e_en) m_rf[e_addr] = e_data;
        if (pq_rd.size() > 0 && (!m_wb_v || m_wb_rd == pq_rd[0])) begin
            void'(pq_rd.pop_front());
            void'(pq_d.pop_front());
        end
        if (lv && !(m_wb_v && m_wb_rd == lrd)) begin
            pq_rd.push_back(lrd);
            pq_d.push_back(ld);
        end
        m_wb_v  = av;
        m_wb_rd = ard;
        m_wb_d  = ad;
    endtask

    task automatic nop(string tag, int ra0, int ra1);
        step(tag, 0, 0, 0, 0, 0, 0, 0, ra0, ra1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) m_rf[i] = 32'h1000_0000 + 32'(i * 7);

        // R1: reset state
        repeat (2) begin
            @(negedge clk);
            rd_addr[0]  = AW'(3);
            rd_addr[1]  = AW'(9);
            rf_rdata[0] = m_rf[3];
            rf_rdata[1] = m_rf[9];
            #1;
            check("R1", "wp_en", 32'(wp_en), 32'd0);
            check("R1", "rd_fwd0", rd_fwd[0], m_rf[3]);
            check("R1", "rd_fwd1", rd_fwd[1], m_rf[9]);
        end
        @(negedge clk);
        rst_n = 1'b1;
        nop("R1", 3, 9);

        // R2: integer result goes out one cycle later
        step("R2", 1, 5, 32'hAAAA_0005, 0, 0, 0, 0, 5, 6);
        nop("R2", 5, 6);
        nop("R2", 5, 0);

        // R3 / R4: return under a stream of integer writes, held then drained
        step("R3", 1, 1, 32'h11, 0, 0, 0, 0, 7, 1);
        step("R3", 1, 2, 32'h22, 0, 1, 7, 32'hBEEF_0007, 7, 2);
        step("R4", 1, 3, 32'h33, 0, 0, 0, 0, 7, 3);
        step("R4", 0, 0, 0, 0, 0, 0, 0, 7, 3);
        nop("R3", 7, 3);
        nop("R3", 7, 0);

        // R5: load/store leaves a free slot for the held entry
        step("R5", 1, 20, 32'h2020, 0, 1, 9, 32'h0909_0909, 9, 20);
        step("R5", 0, 0, 0, 1, 0, 0, 0, 9, 20);
        nop("R5", 9, 20);
        step("R5", 0, 0, 0, 1, 0, 0, 0, 9, 1);
        nop("R5", 9, 1);

        // R6: older entry drains in the slot where a newer one is captured
        step("R6", 1, 21, 32'h2121, 0, 1, 10, 32'h0A0A_0A0A, 10, 11);
        step("R6", 0, 0, 0, 1, 0, 0, 0, 10, 11);
        step("R6", 0, 0, 0, 0, 1, 11, 32'h0B0B_0B0B, 10, 11);
        nop("R6", 10, 11);
        nop("R6", 10, 11);

        // R7: integer write to the held register cancels it
        step("R7", 1, 22, 32'h2222, 0, 1, 12, 32'h0C0C_0C0C, 12, 22);
        step("R7", 1, 12, 32'h7777_000C, 0, 0, 0, 0, 12, 22);
        step("R7", 0, 0, 0, 0, 0, 0, 0, 12, 22);
        nop("R7", 12, 22);
        nop("R7", 12, 0);

        // R8: return to the register being written by a younger integer op
        step("R8", 1, 13, 32'h8888_000D, 0, 0, 0, 0, 13, 0);
        step("R8", 0, 0, 0, 0, 1, 13, 32'hDEAD_000D, 13, 0);
        nop("R8", 13, 0);
        nop("R8", 13, 0);

        // R9 / R10: priority with both sources matching, ports independent
        step("R9", 1, 23, 32'h2323, 0, 1, 14, 32'h0E0E_0E0E, 14, 23);
        step("R9", 1, 15, 32'h1515, 0, 0, 0, 0, 14, 15);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 15, 14);
        nop("R10", 14, 15);

        // mixed traffic under the input rules
        for (int n = 0; n < 4000; n++) begin
            int  op;
            bit  av, mv, lv;
            op = int'($urandom % 4);
            av = (op == 1) || (op == 3);
            mv = (op == 2);
            lv = (($urandom % 3) == 0) && !(pq_rd.size() > 0 && m_wb_v);
            step("RND", av, int'($urandom % 8), $urandom, mv,
                 lv, int'($urandom % 8), $urandom,
                 int'($urandom % 8), int'($urandom % 8));
        end
        repeat (3) nop("RND", 0, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule